// File: doc/BRIEF.md
# Delayed Fast-Command Crossing Counter

This block sits behind the fast-command link of a front-end module and turns a raw command word, one word per 25 ns bunch crossing, into locally aligned actions. Each command bit first passes through its own programmable delay of 0 to 15 crossings. The delay compensates for the latency with which that bit reaches this module, so that every front-end acts on a command in the same crossing.

A decode stage follows the delay. One bit position restarts the local crossing counter. This counter is the identifier with which all outgoing data is tagged, and restarting it is the main means of keeping the whole system in step. The counter does not restart at zero. It loads a preset value chosen through configuration, and it wraps once per orbit. A second bit position freezes a copy of the counter and the delayed command word into a snapshot register. That copy stays in place until the configuration side acknowledges it. All other bit positions are passed on, after their delay, as special commands for the rest of the front-end.

Top module: `fcmd_bxid_sync`

## Requirements
- R1: While `rst_n` is low, `bxid` is 0, `snap_valid` is 0 and `spec_cmd` is all zeros.
- R2: With no counter restart, `bxid` rises by one on every clock edge and goes from 3563 back to 0.
- R3: Bit 0 of the delayed command word restarts the counter. At the end of the cycle in which it is high, `bxid` takes the value of `bx_preset`, and counting resumes from there.
- R4: Command bit b uses the 4-bit delay setting `dly_cfg[4*b+3:4*b]`, with a value d from 0 to 15. A pulse on `cmd_in[b]` appears on the delayed word exactly d cycles later. With d = 0 it appears in the same cycle, with no register in the path.
- R5: When a counter restart falls in the cycle in which `bxid` is 3563, the preset is loaded and the wrap to 0 does not happen.
- R6: `spec_cmd` carries delayed bits 2 to 23 of the command word. Bit positions 0 and 1 are always 0 on `spec_cmd`.
- R7: Bit 1 of the delayed command word requests a snapshot. If `snap_valid` is low at the end of that cycle, `snap_bxid` takes the `bxid` value of that cycle, `snap_cmd` takes the whole delayed command word of that cycle, and `snap_valid` goes high.
- R8: While `snap_valid` is high, further snapshot requests leave `snap_bxid` and `snap_cmd` unchanged. A cycle with `snap_rd` high clears `snap_valid` at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one edge per 25 ns crossing |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 24 | Raw fast-command word, one per crossing |
| dly_cfg | input | 96 | Per-bit delay settings, 4 bits per command bit |
| bx_preset | input | 12 | Value loaded by a counter restart |
| snap_rd | input | 1 | Acknowledges the snapshot and frees the register |
| bxid | output | 12 | Current crossing identifier |
| spec_cmd | output | 24 | Delayed command word with bits 0 and 1 masked |
| snap_valid | output | 1 | Snapshot register holds an unread capture |
| snap_bxid | output | 12 | Captured crossing identifier |
| snap_cmd | output | 24 | Captured delayed command word |

## Verification
A wrong tap in a delay line shows up on `spec_cmd` exactly at the crossing where the pulse should arrive, or at one crossing too early or too late. For bit 0 the same fault shows up as an off-by-the-delay value in every later `bxid`. A counter that loses a step or wraps at the wrong count drifts from the expected identifier at once and keeps the error for the rest of the orbit. The long free run and the six restart cases in the vector table expose this. A snapshot register that overwrites itself, or ignores the acknowledge, is caught on the first repeated request.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
   // bit positions inside the delayed command word that the decode stage claims
   localparam int unsigned FC_RST_BIT  = 0;
   localparam int unsigned FC_SNAP_BIT = 1;
endpackage

// File: rtl/fcmd_dly_bit.sv
module fcmd_dly_bit #(
   parameter int unsigned MAX_DLY = 16,
   localparam int unsigned SEL_W  = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             din,
   output logic             dout
);
   generate
      if (MAX_DLY < 1) begin : g_bad
         $error("fcmd_dly_bit: MAX_DLY must be at least 1");
      end else if (MAX_DLY == 1) begin : g_wire
         assign dout = din;
      end else begin : g_line
         logic [MAX_DLY-2:0] stage;
         logic [MAX_DLY-1:0] tap;

         assign tap  = {stage, din};
         assign dout = tap[sel];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= '0;
            else        stage <= tap[MAX_DLY-2:0];
         end

         // R4: one stage of history per crossing
         assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> stage[0] == $past(din));
      end
   endgenerate
endmodule

// File: rtl/fcmd_filter.sv
module fcmd_filter
   import fcmd_pkg::*;
#(
   parameter int unsigned CMD_W = 24
) (
   input  logic [CMD_W-1:0] dly_word,
   output logic             bx_load,
   output logic             snap_req,
   output logic [CMD_W-1:0] spec_cmd
);
   generate
      if (CMD_W <= FC_SNAP_BIT || CMD_W <= FC_RST_BIT) begin : g_bad
         $error("fcmd_filter: command word too narrow for decoded bits");
      end
   endgenerate

   always_comb begin
      bx_load  = dly_word[FC_RST_BIT];
      snap_req = dly_word[FC_SNAP_BIT];
      spec_cmd = dly_word;
      spec_cmd[FC_RST_BIT]  = 1'b0;
      spec_cmd[FC_SNAP_BIT] = 1'b0;
   end
endmodule

// File: rtl/fcmd_bx_counter.sv
module fcmd_bx_counter #(
   parameter int unsigned BX_W      = 12,
   parameter int unsigned BX_PERIOD = 3564,
   localparam logic [BX_W-1:0] BX_LAST = BX_W'(BX_PERIOD - 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [BX_W-1:0] preset,
   output logic [BX_W-1:0] bxid
);
   generate
      if (BX_PERIOD < 2 || BX_PERIOD > (1 << BX_W)) begin : g_bad
         $error("fcmd_bx_counter: BX_PERIOD does not fit BX_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bxid <= '0;
      else if (load)             bxid <= preset;
      else if (bxid == BX_LAST)  bxid <= '0;
      else                       bxid <= bxid + 1'b1;
   end

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && bxid != BX_LAST) |=> bxid == BX_W'($past(bxid) + 1'b1));
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && bxid == BX_LAST) |=> bxid == '0);
   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> bxid == $past(preset));
   assert_preset_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && bxid == BX_LAST && preset != '0) |=> bxid != '0);
endmodule

// File: rtl/fcmd_snap.sv
module fcmd_snap #(
   parameter int unsigned BX_W  = 12,
   parameter int unsigned CMD_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             rd,
   input  logic [BX_W-1:0]  bxid_in,
   input  logic [CMD_W-1:0] word_in,
   output logic             valid,
   output logic [BX_W-1:0]  held_bxid,
   output logic [CMD_W-1:0] held_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid     <= 1'b0;
         held_bxid <= '0;
         held_word <= '0;
      end else if (req && !valid) begin
         valid     <= 1'b1;
         held_bxid <= bxid_in;
         held_word <= word_in;
      end else if (rd) begin
         valid     <= 1'b0;
      end
   end

   assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !valid) |=> valid && held_bxid == $past(bxid_in) && held_word == $past(word_in));
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !rd) |=> valid && $stable(held_bxid) && $stable(held_word));
   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && rd) |=> !valid);
endmodule

// File: rtl/fcmd_bxid_sync.sv
module fcmd_bxid_sync
   import fcmd_pkg::*;
#(
   parameter int unsigned CMD_W     = 24,
   parameter int unsigned MAX_DLY   = 16,
   parameter int unsigned BX_W      = 12,
   parameter int unsigned BX_PERIOD = 3564,
   localparam int unsigned DLY_W    = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CMD_W-1:0]       cmd_in,
   input  logic [CMD_W*DLY_W-1:0] dly_cfg,
   input  logic [BX_W-1:0]        bx_preset,
   input  logic                   snap_rd,
   output logic [BX_W-1:0]        bxid,
   output logic [CMD_W-1:0]       spec_cmd,
   output logic                   snap_valid,
   output logic [BX_W-1:0]        snap_bxid,
   output logic [CMD_W-1:0]       snap_cmd
);
   generate
      if (MAX_DLY > 1 && (1 << DLY_W) != MAX_DLY) begin : g_bad_dly
         $error("fcmd_bxid_sync: MAX_DLY must be a power of two");
      end
   endgenerate

   logic [CMD_W-1:0] dly_word;
   logic             bx_load;
   logic             snap_req;

   for (genvar b = 0; b < CMD_W; b++) begin : g_bit
      fcmd_dly_bit #(.MAX_DLY(MAX_DLY)) u_dly (
         .clk  (clk),
         .rst_n(rst_n),
         .sel  (dly_cfg[b*DLY_W +: DLY_W]),
         .din  (cmd_in[b]),
         .dout (dly_word[b])
      );
   end

   fcmd_filter #(.CMD_W(CMD_W)) u_filter (
      .dly_word(dly_word),
      .bx_load (bx_load),
      .snap_req(snap_req),
      .spec_cmd(spec_cmd)
   );

   fcmd_bx_counter #(.BX_W(BX_W), .BX_PERIOD(BX_PERIOD)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (bx_load),
      .preset(bx_preset),
      .bxid  (bxid)
   );

   fcmd_snap #(.BX_W(BX_W), .CMD_W(CMD_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (snap_req),
      .rd       (snap_rd),
      .bxid_in  (bxid),
      .word_in  (dly_word),
      .valid    (snap_valid),
      .held_bxid(snap_bxid),
      .held_word(snap_cmd)
   );

   // R6: decoded positions never leak onto the special-command output
   assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      spec_cmd[FC_RST_BIT] == 1'b0 && spec_cmd[FC_SNAP_BIT] == 1'b0);
   // R1: reset state visible during reset
   always_comb begin
      if (!rst_n) assert_rst_state_R1: assert (bxid == '0 && !snap_valid) else ;
   end
endmodule

// File: tb/tb_fcmd_bxid_sync.sv
`timescale 1ns/1ps
module tb_fcmd_bxid_sync;
   localparam int CMD_W = 24, DLY_W = 4, BX_W = 12, PERIOD = 3564;
   localparam int NV = 6;
   // vector table: restart delay, preset, edges after load, expected bxid
   localparam int VD[NV] = '{0,    3,  15,   7,  1,   15};
   localparam int VP[NV] = '{100,  0, 3563, 3000, 2, 1234};
   localparam int VM[NV] = '{5,    0,   1,  600, 10,   0};
   localparam int VE[NV] = '{105,  0,   0,   36, 12, 1234};

   logic clk = 1'b0, rst_n = 1'b0, snap_rd = 1'b0;
   logic [CMD_W-1:0] cmd_in = '0;
   logic [CMD_W*DLY_W-1:0] dly_cfg = '0;
   logic [BX_W-1:0] bx_preset = '0;
   logic [BX_W-1:0] bxid, snap_bxid;
   logic [CMD_W-1:0] spec_cmd, snap_cmd;
   logic snap_valid;
   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   fcmd_bxid_sync dut (
      .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .dly_cfg(dly_cfg),
      .bx_preset(bx_preset), .snap_rd(snap_rd), .bxid(bxid),
      .spec_cmd(spec_cmd), .snap_valid(snap_valid), .snap_bxid(snap_bxid),
      .snap_cmd(snap_cmd)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_dly(input int b, input int d);
      dly_cfg[b*DLY_W +: DLY_W] = DLY_W'(d);
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int b0;
      logic [BX_W-1:0] held;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 bxid", bxid, 0);
      check("R1 snap_valid", snap_valid, 0);
      check("R1 spec_cmd", spec_cmd, 0);
      rst_n = 1'b1;
      // R2 free run and wrap
      edges(10);
      check("R2 count", bxid, 10);
      edges(3553);
      check("R2 last", bxid, 3563);
      edges(1);
      check("R2 wrap", bxid, 0);
      // R5 restart coinciding with wrap
      edges(3563);
      check("R5 at last", bxid, 3563);
      bx_preset = 12'd77;
      cmd_in[0] = 1'b1;
      @(posedge clk); @(negedge clk);
      cmd_in = '0;
      check("R5 preset wins", bxid, 77);
      // R3/R4 vector table: restart through bit 0 with several delays
      for (int v = 0; v < NV; v++) begin
         set_dly(0, VD[v]);
         bx_preset = BX_W'(VP[v]);
         cmd_in[0] = 1'b1;
         @(posedge clk); @(negedge clk);
         cmd_in = '0;
         if (VD[v] + VM[v] > 0) edges(VD[v] + VM[v]);
         check($sformatf("R3 R4 vector %0d", v), bxid, VE[v]);
      end
      set_dly(0, 0);
      // R4 delay of 4 on bit 5, zero delay on bit 6
      set_dly(5, 4);
      cmd_in[5] = 1'b1; cmd_in[6] = 1'b1;
      #1;
      check("R4 bit5 not yet", spec_cmd[5], 0);
      check("R4 bit6 zero delay", spec_cmd[6], 1);
      for (int k = 1; k <= 5; k++) begin
         edges(1);
         if (k == 1) cmd_in = '0;
         #1;
         check($sformatf("R4 bit5 after %0d", k), spec_cmd[5], (k == 4) ? 1 : 0);
      end
      // R6 bit 0 masked even at zero delay
      bx_preset = 12'd500;
      cmd_in[0] = 1'b1; cmd_in[23] = 1'b1;
      #1;
      check("R6 bit0 masked", spec_cmd[0], 0);
      check("R6 bit23 passes", spec_cmd[23], 1);
      edges(1);
      cmd_in = '0;
      // R7 snapshot via bit 1 with bit 9, both delay 2
      set_dly(1, 2); set_dly(9, 2);
      b0 = int'(bxid);
      cmd_in[1] = 1'b1; cmd_in[9] = 1'b1;
      edges(1);
      cmd_in = '0;
      edges(1);
      check("R6 bit1 masked", spec_cmd[1], 0);
      check("R6 bit9 delayed", spec_cmd[9], 1);
      check("R7 not yet valid", snap_valid, 0);
      edges(1);
      check("R7 valid", snap_valid, 1);
      check("R7 bxid", snap_bxid, (b0 + 2) % PERIOD);
      check("R7 word", snap_cmd, (1 << 1) | (1 << 9));
      held = snap_bxid;
      // R8 second request ignored while valid
      cmd_in[1] = 1'b1;
      edges(1);
      cmd_in = '0;
      edges(4);
      check("R8 still valid", snap_valid, 1);
      check("R8 bxid kept", snap_bxid, held);
      check("R8 word kept", snap_cmd, (1 << 1) | (1 << 9));
      snap_rd = 1'b1;
      edges(1);
      snap_rd = 1'b0;
      check("R8 cleared", snap_valid, 0);
      // R7 fresh capture after acknowledge
      b0 = int'(bxid);
      cmd_in[1] = 1'b1;
      edges(1);
      cmd_in = '0;
      edges(2);
      check("R7 recapture valid", snap_valid, 1);
      check("R7 recapture bxid", snap_bxid, (b0 + 2) % PERIOD);
      check("R7 recapture word", snap_cmd, 1 << 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule